// File: doc/BRIEF.md
# Edge-capture interrupt unit

This unit watches the lower 24 lines of a 48-line digital I/O controller. These are ports 0, 1 and 2, with eight lines each. It records transitions on those lines as interrupt events. Each line has its own polarity bit and its own enable bit. The polarity bit chooses whether a rising or a falling transition counts. The enable bit decides whether that line may record an event at all. Recorded events sit in three 8-bit event registers, one per port. Each bit stays set until software clears it. A 3-bit summary shows which ports hold events, and a level interrupt request stays high while any port does.

Line levels arrive asynchronously. They pass through a two-stage synchronizer, and each synchronized level is compared with the level from one cycle earlier. The polarity setting only selects which kind of change counts. Rewriting it while a line is steady therefore records nothing. Software clears events with a write strobe, a port index and a data byte. Register decoding belongs to the surrounding register interface, and so do the upper 24 lines.

Top module: `edge_irq_capture`

## Requirements
- R1: While `rst_n` is low, `id_q`, `pend` and `irq` are all zero.
- R2: Line `8*n+b` maps to event bit `id_q[8*n+b]` (port n, bit b). With polarity 1 and enable 1, a 0-to-1 change on the line sets that bit. The bit is visible at the third rising clock edge after the line changes and not at the second.
- R3: With polarity 0 and enable 1, a 1-to-0 change on a line sets its event bit.
- R4: A change in the direction that the polarity bit does not select records nothing. A line whose enable bit is 0 records nothing in either direction.
- R5: An event bit stays set after its line returns to its former level, until a clearing write reaches it.
- R6: A clearing write is `clr_we` high for one cycle, with `clr_sel` holding the port index (0 to 2). Each bit of that port's event register whose `clr_data` bit is 0 is cleared, and each bit whose `clr_data` bit is 1 is kept. Writing 0x00 clears the whole register.
- R7: `pend[n]` is 1 exactly when the event register of port n is nonzero. `irq` is high exactly when any `pend` bit is high.
- R8: When a clearing write and a new event hit the same bit in the same cycle, the bit is left set. Other bits named by the same write are cleared.
- R9: Changing polarity bits while the lines stay steady records no event.
- R10: A line held at a steady level through reset and after it records no event once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 24 | Raw line levels, port n on bits 8n+7..8n |
| pol | input | 24 | Per-line polarity: 1 rising, 0 falling |
| en | input | 24 | Per-line capture enable |
| clr_we | input | 1 | Clearing write strobe |
| clr_sel | input | 2 | Port index of the clearing write |
| clr_data | input | 8 | Write data: 0 bits clear, 1 bits keep |
| id_q | output | 24 | Sticky event registers, port n on bits 8n+7..8n |
| pend | output | 3 | Per-port nonzero summary |
| irq | output | 1 | Level interrupt request |

## Verification
The two functions that can fall in the same cycle are the capture of a new edge and a clearing write to the same event register. The bench provokes this by changing a line and then issuing a clear of 0x00 to that port two cycles later. At that point the detected edge and the write meet at the same clock edge. The result passes only if the newly hit bit survives while a previously set bit of the same register is cleared, and the summary and request must follow.

// File: rtl/edge_irq_capture.sv
module edge_irq_capture #(
  parameter int PORTS = 3,
  parameter int PW    = 8,
  localparam int NL   = PORTS * PW,
  localparam int SW   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] line_in,
  input  logic [NL-1:0] pol,
  input  logic [NL-1:0] en,
  input  logic          clr_we,
  input  logic [SW-1:0] clr_sel,
  input  logic [PW-1:0] clr_data,
  output logic [NL-1:0] id_q,
  output logic [PORTS-1:0] pend,
  output logic          irq
);

  logic [NL-1:0] s1, s2, hist, rise, fall, evt, keep;
  logic [2:0]    arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      hist <= '0;
      arm  <= '0;
    end else begin
      s1   <= line_in;
      s2   <= s1;
      hist <= s2;
      arm  <= {arm[1:0], 1'b1};
    end
  end

  assign rise = s2 & ~hist;
  assign fall = ~s2 & hist;
  assign evt  = arm[2] ? (en & ((pol & rise) | (~pol & fall))) : '0;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign keep[p*PW +: PW] = (clr_we && clr_sel == SW'(p)) ? clr_data : '1;
    assign pend[p] = |id_q[p*PW +: PW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= '0;
    else        id_q <= (id_q & keep) | evt;
  end

  assign irq = |pend;

  // R7
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (id_q != '0));

  // R10
  warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm[2] |-> id_q == '0);

  for (genvar i = 0; i < NL; i++) begin : g_bit
    // R4
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_q[i]) |-> $past(en[i]));

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_q[i] && !(clr_we && clr_sel == SW'(i / PW) && !clr_data[i % PW])) |=> id_q[i]);

    // R6
    clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_sel == SW'(i / PW) && !clr_data[i % PW] && !evt[i]) |=> !id_q[i]);

    // R8
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> id_q[i]);
  end

endmodule

// File: tb/edge_irq_capture_bench.sv
module edge_irq_capture_bench;
  localparam int NL = 24;

  logic clk = 0;
  logic rst_n = 0;
  logic [NL-1:0] line_in = '1;
  logic [NL-1:0] pol = '1;
  logic [NL-1:0] en = '1;
  logic clr_we = 0;
  logic [1:0] clr_sel = '0;
  logic [7:0] clr_data = '0;
  logic [NL-1:0] id_q;
  logic [2:0] pend;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [NL-1:0] exp_id = '0;
  logic [NL-1:0] q_id[$];
  string q_tag[$];

  always #2 clk = ~clk;

  edge_irq_capture u_edge_irq_capture (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .pol(pol), .en(en),
    .clr_we(clr_we), .clr_sel(clr_sel), .clr_data(clr_data),
    .id_q(id_q), .pend(pend), .irq(irq));

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(string tag);
    q_tag.push_back(tag);
    q_id.push_back(exp_id);
  endtask

  task automatic clear(int p, logic [7:0] d);
    clr_we = 1; clr_sel = 2'(p); clr_data = d;
    step(1);
    clr_we = 0;
  endtask

  initial begin : monitor
    forever begin
      logic [NL-1:0] e;
      logic [2:0] ep;
      string t;
      wait (q_id.size() > 0);
      e = q_id.pop_front();
      t = q_tag.pop_front();
      ep = {|e[23:16], |e[15:8], |e[7:0]};
      n_chk++;
      if (id_q !== e || pend !== ep || irq !== (|ep)) begin
        n_bad++;
        $display("FAIL %s: id=%h pend=%b irq=%b expected id=%h pend=%b irq=%b",
                 t, id_q, pend, irq, e, ep, |ep);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    step(3);
    expect_now("R1 reset");
    rst_n = 1;
    step(5);
    expect_now("R10 steady high through reset");

    pol[7:0] = 8'h00;
    step(2);
    line_in[3] = 0;
    step(3);
    exp_id[3] = 1;
    expect_now("R3 falling edge");

    line_in[3] = 1;
    step(3);
    expect_now("R5 sticky / R4 opposite direction");

    line_in[9] = 0;
    step(3);
    expect_now("R4 falling ignored under rising polarity");
    line_in[9] = 1;
    step(2);
    expect_now("R2 not yet at second edge");
    step(1);
    exp_id[9] = 1;
    expect_now("R2 rising edge latency / R7 two ports");

    en[20] = 0;
    line_in[20] = 0;
    step(3);
    line_in[20] = 1;
    step(3);
    expect_now("R4 disabled line");

    clear(1, 8'h00);
    exp_id[9] = 0;
    expect_now("R6 clear whole port");
    clear(0, 8'hFF);
    expect_now("R6 all-ones write keeps");
    clear(0, 8'hF7);
    exp_id[3] = 0;
    expect_now("R6 selective clear / R7 irq low");

    pol = '0;
    step(1);
    pol = 24'h5A5A5A;
    step(1);
    pol = '1;
    step(3);
    expect_now("R9 polarity change");

    line_in[16] = 0;
    line_in[17] = 0;
    step(3);
    line_in[17] = 1;
    step(3);
    exp_id[17] = 1;
    expect_now("R2 bit 17 rising");
    line_in[16] = 1;
    step(2);
    clear(2, 8'h00);
    exp_id[16] = 1;
    exp_id[17] = 0;
    expect_now("R8 edge wins over clear");

    line_in[7:0] = 8'h00;
    step(3);
    expect_now("R4 falling ignored port0");
    line_in[7:0] = 8'hFF;
    step(3);
    exp_id[7:0] = 8'hFF;
    expect_now("R2 eight lines at once / R7");

    rst_n = 0;
    step(1);
    exp_id = '0;
    expect_now("R1 reset again");

    step(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule